// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block is the digital side of the feedback divider in a fractional-N frequency synthesizer. Software loads an 8-bit integer word, a 12-bit fractional word, an 11-bit signed correction word and a prescaler-range bit through a small parallel write port. The block combines the fractional and correction words into one 15-bit fraction, so each fraction LSB is 1/32768 of the comparison frequency. A third-order multi-stage noise-shaping modulator turns that fraction into a small integer offset for each comparison period. The integer word plus that offset is the instantaneous division ratio N. A pulse-swallow A/B counter turns N into a modulus-select signal for a dual-modulus prescaler whose range is 4/5 or 8/9.

The clock of the block is the prescaler output. A divide period lasts B = N / P clocks, where P is the lower prescaler modulus. The modulus-select output is high for the first A = N mod P of those clocks, so the oscillator sees P*B + A = N cycles per period. A single-clock pulse on `div_done` marks the last clock of every period. Register writes are held in a shadow copy and become active together at a period boundary. Integer words must lie between P*P + 3P + 3 and 255 for the chosen prescaler.

Top module: `fracn_divider`

## Requirements
- R1: After reset the active settings are integer 31, fraction 0, correction 0 and the 4/5 prescaler, so every divide period lasts 7 clocks with `mod_sel` high in its first 3 clocks, and `div_done` is low while reset is held.
- R2: For the active ratio N and lower modulus P (4 when the prescaler bit is 0, 8 when it is 1), a period lasts N/P clocks, `mod_sel` is high in exactly the first N mod P of them, and `div_done` is high only in the last clock of each period.
- R3: A write with `wr_en` high stores `wr_data` by `wr_addr`: address 0 takes the integer word from bits 7..0, address 1 the fractional word from bits 11..0, address 2 the two's-complement correction from bits 10..0, and address 3 the prescaler bit from bit 0 (1 selects 8/9).
- R4: A write never alters the period in progress; all stored values take effect together from the period that starts after the next `div_done`.
- R5: The 15-bit fraction is the fractional word shifted left by 3 plus the sign-extended correction word, wrapped modulo 32768.
- R6: With a fraction F that is a multiple of 16, the oscillator cycle count (sum of P plus `mod_sel` over each clock) over any 2048 consecutive periods equals 2048 times the integer plus F/16, within 4.
- R7: The modulator offset added to the integer lies between -3 and +4, and the modulator state advances only at a period boundary.
- R8: A negative correction lowers the average ratio by its magnitude in fraction LSBs; a positive one raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 12 | Write data |
| mod_sel | output | 1 | Prescaler modulus select, high for the upper modulus |
| div_done | output | 1 | High in the last clock of each divide period |

## Verification
A write is captured at the clock edge it is presented on. It is seen first in the period that follows the next `div_done`, so the bench writes in the first clock of a period and expects the old period length once more before the new one. Period length and `mod_sel` count are taken at falling edges, counting from the clock after one `div_done` through the next. The first clock of a period is already the first high clock of `mod_sel`. Averages are checked only after several periods have passed since the last write, so that no period mixes old and new settings.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    typedef enum logic [1:0] {
        ADDR_INT   = 2'd0,
        ADDR_FRAC  = 2'd1,
        ADDR_CORR  = 2'd2,
        ADDR_PRESC = 2'd3
    } cfg_addr_t;

    localparam int LOW_P_NARROW = 4;
    localparam int LOW_P_WIDE   = 8;
endpackage

// File: rtl/fracn_regs.sv
module fracn_regs
    import fracn_pkg::*;
#(
    parameter int INT_W   = 8,
    parameter int NFRAC_W = 12,
    parameter int CORR_W  = 11,
    parameter int DATA_W  = 12,
    parameter int INT_RST = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                commit,
    output logic [INT_W-1:0]    ival_o,
    output logic [NFRAC_W-1:0]  fval_o,
    output logic [CORR_W-1:0]   cval_o,
    output logic                wide_o
);
    typedef struct packed {
        logic [INT_W-1:0]   ival;
        logic [NFRAC_W-1:0] fval;
        logic [CORR_W-1:0]  cval;
        logic               wide;
    } cfg_t;

    typedef struct packed {
        cfg_t shadow;
        cfg_t active;
    } st_t;

    localparam cfg_t CFG_RST = '{ival: INT_W'(INT_RST), fval: '0, cval: '0, wide: 1'b0};

    st_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (cfg_addr_t'(wr_addr))
                ADDR_INT:   d.shadow.ival = wr_data[INT_W-1:0];
                ADDR_FRAC:  d.shadow.fval = wr_data[NFRAC_W-1:0];
                ADDR_CORR:  d.shadow.cval = wr_data[CORR_W-1:0];
                default:    d.shadow.wide = wr_data[0];
            endcase
        end
        if (commit) begin
            d.active = d.shadow;
        end
        ival_o = d.active.ival;
        fval_o = d.active.fval;
        cval_o = d.active.cval;
        wide_o = d.active.wide;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{shadow: CFG_RST, active: CFG_RST};
        end else begin
            q <= d;
        end
    end

    // R4
    hold_until_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(q.active));
endmodule

// File: rtl/fracn_mash3.sv
module fracn_mash3 #(
    parameter int FRAC_W = 15,
    parameter int OFS_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic [FRAC_W-1:0]        frac,
    output logic signed [OFS_W-1:0]  ofs_o
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc1;
        logic [FRAC_W-1:0] acc2;
        logic [FRAC_W-1:0] acc3;
        logic              c2_z;
        logic              c3_z1;
        logic              c3_z2;
    } st_t;

    st_t q, d;
    logic [FRAC_W:0] s1, s2, s3;
    logic c1, c2, c3;
    int ofs_i;

    always_comb begin
        d  = q;
        s1 = {1'b0, q.acc1} + {1'b0, frac};
        s2 = {1'b0, q.acc2} + {1'b0, s1[FRAC_W-1:0]};
        s3 = {1'b0, q.acc3} + {1'b0, s2[FRAC_W-1:0]};
        c1 = s1[FRAC_W];
        c2 = s2[FRAC_W];
        c3 = s3[FRAC_W];
        ofs_i = int'(c1) + int'(c2) - int'(q.c2_z)
              + int'(c3) - 2 * int'(q.c3_z1) + int'(q.c3_z2);
        ofs_o = OFS_W'(ofs_i);
        if (step) begin
            d.acc1  = s1[FRAC_W-1:0];
            d.acc2  = s2[FRAC_W-1:0];
            d.acc3  = s3[FRAC_W-1:0];
            d.c2_z  = c2;
            d.c3_z1 = c3;
            d.c3_z2 = q.c3_z1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R7
    ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (ofs_o >= -4'sd3 && ofs_o <= 4'sd4));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(q.acc1) && $stable(q.acc2) && $stable(q.acc3)));
endmodule

// File: rtl/fracn_swallow.sv
module fracn_swallow
    import fracn_pkg::*;
#(
    parameter int N_W     = 9,
    parameter int INT_RST = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_W-1:0]  n_next,
    input  logic            wide_next,
    output logic            mod_sel_o,
    output logic            done_o
);
    localparam int POS_W = N_W - 1;
    localparam int A_W   = $clog2(LOW_P_WIDE);
    localparam int SH_N  = $clog2(LOW_P_NARROW);
    localparam int SH_W  = $clog2(LOW_P_WIDE);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [POS_W-1:0] b;
        logic [A_W-1:0]   a;
    } st_t;

    st_t q, d;
    int sh;

    always_comb begin
        d  = q;
        sh = wide_next ? SH_W : SH_N;
        done_o    = (q.pos == q.b - 1'b1);
        mod_sel_o = (q.pos < POS_W'(q.a));
        if (done_o) begin
            d.pos = '0;
            d.b   = POS_W'(n_next >> sh);
            d.a   = A_W'(n_next & ((N_W'(1) << sh) - 1'b1));
        end else begin
            d.pos = q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{pos: '0,
                   b: POS_W'(INT_RST / LOW_P_NARROW),
                   a: A_W'(INT_RST % LOW_P_NARROW)};
        end else begin
            q <= d;
        end
    end

    // R2
    swallow_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (POS_W'(q.a) <= q.b));

    // R2
    done_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    sel_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (d.a != '0)) |=> mod_sel_o);
endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
    import fracn_pkg::*;
#(
    parameter int INT_W   = 8,
    parameter int NFRAC_W = 12,
    parameter int CORR_W  = 11,
    parameter int FRAC_W  = 15,
    parameter int OFS_W   = 4,
    parameter int INT_RST = 31,
    parameter int DATA_W  = NFRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mod_sel,
    output logic              div_done
);
    localparam int N_W = INT_W + 1;
    localparam int FSH = FRAC_W - NFRAC_W;

    logic [INT_W-1:0]          ival;
    logic [NFRAC_W-1:0]        fval;
    logic [CORR_W-1:0]         cval;
    logic                      wide;
    logic [FRAC_W-1:0]         frac_sum;
    logic signed [OFS_W-1:0]   ofs;
    logic [N_W-1:0]            n_next;
    int                        n_sum;

    fracn_regs #(
        .INT_W(INT_W), .NFRAC_W(NFRAC_W), .CORR_W(CORR_W),
        .DATA_W(DATA_W), .INT_RST(INT_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(div_done),
        .ival_o(ival), .fval_o(fval), .cval_o(cval), .wide_o(wide)
    );

    always_comb begin
        frac_sum = {fval, {FSH{1'b0}}}
                 + {{(FRAC_W-CORR_W){cval[CORR_W-1]}}, cval};
        n_sum    = int'(ival) + int'(ofs);
        n_next   = N_W'(n_sum);
    end

    fracn_mash3 #(.FRAC_W(FRAC_W), .OFS_W(OFS_W)) u_mash (
        .clk(clk), .rst_n(rst_n), .step(div_done),
        .frac(frac_sum), .ofs_o(ofs)
    );

    fracn_swallow #(.N_W(N_W), .INT_RST(INT_RST)) u_swallow (
        .clk(clk), .rst_n(rst_n), .n_next(n_next), .wide_next(wide),
        .mod_sel_o(mod_sel), .done_o(div_done)
    );
endmodule

// File: tb/fracn_divider_test.sv
module fracn_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [11:0] wr_data = 12'd0;
    logic        mod_sel;
    logic        div_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fracn_divider uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mod_sel(mod_sel), .div_done(div_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!div_done);
    endtask

    task automatic measure(output int len, output int hi);
        len = 0;
        hi  = 0;
        do begin
            @(negedge clk);
            len++;
            hi += int'(mod_sel);
        end while (!div_done);
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        int l, h;
        wait_done();
        for (int i = 0; i < 4; i++) measure(l, h);
    endtask

    task automatic expect_period(input int p, input int n, input string tag);
        int l, h;
        measure(l, h);
        check(l == n / p, {tag, " length"}, l, n / p);
        check(h == n % p, {tag, " select count"}, h, n % p);
        check(p * l + h == n, {tag, " oscillator count"}, p * l + h, n);
    endtask

    task automatic t_reset();
        int l, h;
        check(div_done == 1'b0, "R1 done low in reset", int'(div_done), 0);
        rst_n = 1'b1;
        wait_done();
        for (int i = 0; i < 3; i++) expect_period(4, 31, "R1 reset period");
    endtask

    task automatic t_latency();
        int l, h;
        wait_done();
        l = 0; h = 0;
        do begin
            @(negedge clk);
            if (l == 0) begin
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = 12'd100;
            end else begin
                wr_en = 1'b0;
            end
            l++;
            h += int'(mod_sel);
        end while (!div_done);
        check(l == 7, "R4 current period kept", l, 7);
        check(h == 3, "R4 current select kept", h, 3);
        expect_period(4, 100, "R3 R4 new integer");
    endtask

    task automatic t_wide();
        wr(2'd3, 12'd1);
        settle();
        expect_period(8, 100, "R2 R3 wide prescaler");
        wr(2'd0, 12'd255);
        settle();
        expect_period(8, 255, "R2 maximum integer");
        wr(2'd3, 12'd0);
        wr(2'd0, 12'd40);
        settle();
        expect_period(4, 40, "R2 narrow prescaler");
    endtask

    task automatic t_avg(input logic [11:0] fr, input logic [10:0] co,
                         input int f16, input string tag);
        int l, h, total, exp;
        wr(2'd1, fr);
        wr(2'd2, {1'b0, co});
        settle();
        total = 0;
        for (int i = 0; i < 2048; i++) begin
            measure(l, h);
            total += 4 * l + h;
        end
        exp = 2048 * 40 + f16;
        check((total - exp) <= 4 && (exp - total) <= 4, tag, total, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_latency();
        t_wide();
        t_avg(12'h124, 11'd0,     146,  "R6 fractional average");
        t_avg(12'h800, 11'h700,   1008, "R8 R5 negative correction");
        t_avg(12'h000, 11'd208,   13,   "R8 positive correction");
        t_avg(12'hFFE, 11'd32,    1,    "R5 fraction wrap");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule